// File: doc/BRIEF.md
# GPIO interrupt channel multiplexer

This block routes a wide vector of GPIO pad inputs onto eight interrupt lines. Each line has its own pad selector, an optional inverter, a glitch filter and a choice between level and edge sensing. Whatever the pad polarity, the line always leaves the block active-high. A level line holds the possibly inverted pad level. An edge line gives a single-clock pulse each time the possibly inverted, filtered signal rises. So an active-low level comes out as a high level, and a falling pad edge comes out as a rising pulse. A line senses one edge direction only, because one bit picks the direction. Both directions at once cannot be encoded.

Software programs the block through four 32-bit words on a plain register bus with address, write enable, write data and combinational read data. Every pad passes through a two-flop synchronizer. After that, each channel runs a filter state machine with two states. FLT_SETTLED holds the filtered value while the selected input agrees with it. When the input differs from the filtered value, the machine takes SETTLED→QUALIFY, and when the filter length is zero it updates the filtered value at once and stays in SETTLED. In FLT_QUALIFY it counts cycles in which the input still differs. It takes QUALIFY→SETTLED with an update once the count reaches the filter length. It takes QUALIFY→SETTLED without an update when the input returns to the filtered value. A change to a channel's edge, invert or select setting forces the machine to SETTLED and reloads both the filtered value and the edge history from the new input, so reprogramming a channel cannot produce a pulse.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads 0 and every `irq_out` bit is 0.
- R2: Word 0x0 stores bits 7:0 (edge enables) and bits 23:16 (invert enables), and its other bits read 0. Words 0x4, 0x8 and 0xC store and read back all 32 bits. A write takes effect at the next clock. An access whose address has bit 1 or bit 0 set is ignored on write and reads 0.
- R3: Channel n (n<4) takes its pad number from bits [8n+7:8n] of word 0x4. Channel n (n≥4) takes it from bits [8(n-4)+7:8(n-4)] of word 0x8.
- R4: A channel in level mode that is not inverted and has filter length 0 copies its pad to `irq_out`. A pad change driven between two clock edges appears on the output after the third following rising edge. Other channels are unaffected.
- R5: Setting bit 16+n of word 0x0 inverts channel n, so in level mode `irq_out[n]` is the complement of the pad.
- R6: Setting bit n of word 0x0 puts channel n in edge mode. A rising pad edge gives `irq_out[n]` high for exactly one cycle, with the same three-edge latency as R4, and a falling edge gives nothing.
- R7: With both edge and invert set, a falling pad edge gives the one-cycle pulse and a rising edge gives nothing.
- R8: The 4-bit field at bits [4n+3:4n] of word 0xC is filter length L for channel n. A change passes only after L+1 consecutive equal synchronized samples, which adds L cycles of latency. A pulse shorter than that is discarded.
- R9: A select value of 200 (the default pad count) or above routes constant 0 before inversion.
- R10: Changing a channel's select, edge or invert setting produces no pulse, even when the newly selected pad differs from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pads | input | NUM_PADS | Asynchronous GPIO pad levels |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 8 | Active-high interrupt lines, one per channel |

## Verification
The hardest case to reach is the reconfiguration hazard. Channel 0 is in edge mode, its current pad is low and another pad is already high and settled when the select is switched to that pad. Without the reload, the filter would accept the new high value one cycle after the write, and the edge detector would report it as a rising edge. The bench sets up exactly this state, then checks the first four cycles after the write for silence. It then checks that a genuine edge on the new pad still pulses. Filter glitches are placed at exactly L samples against a longer hold, which tests the L+1 boundary from both sides.

// File: rtl/gir_pkg.sv
package gir_pkg;
    localparam int CH      = 8;
    localparam int SEL_W   = 8;
    localparam int FLT_W   = 4;
    localparam int DATA_W  = 32;
    localparam int INV_LSB = 16;
    localparam int SPAN    = 1 << SEL_W;
    localparam int PER_WORD = DATA_W / SEL_W;

    typedef struct packed {
        logic             edge_en;
        logic             inv_en;
        logic [SEL_W-1:0] sel;
        logic [FLT_W-1:0] flt;
    } ch_cfg_t;

    typedef enum logic [1:0] {
        ADR_MODE   = 2'd0,
        ADR_SEL_LO = 2'd1,
        ADR_SEL_HI = 2'd2,
        ADR_FLT    = 2'd3
    } reg_idx_t;

    typedef enum logic {
        FLT_SETTLED = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_t;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gir_regs.sv
module gir_regs
    import gir_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output ch_cfg_t [CH-1:0]    cfg
);
    localparam int WORD_LSB = 2;
    localparam int NWORDS   = 4;

    logic [CH-1:0]     edge_q, inv_q;
    logic [DATA_W-1:0] sel_lo_q, sel_hi_q, flt_q;
    logic              hit;
    reg_idx_t          idx;

    assign hit = (addr[WORD_LSB-1:0] == '0) && ((addr >> WORD_LSB) < NWORDS);
    assign idx = reg_idx_t'(addr[WORD_LSB +: 2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q   <= '0;
            inv_q    <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            flt_q    <= '0;
        end else if (we && hit) begin
            unique case (idx)
                ADR_MODE: begin
                    edge_q <= wdata[CH-1:0];
                    inv_q  <= wdata[INV_LSB +: CH];
                end
                ADR_SEL_LO: sel_lo_q <= wdata;
                ADR_SEL_HI: sel_hi_q <= wdata;
                ADR_FLT:    flt_q    <= wdata;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (idx)
                ADR_MODE: begin
                    rdata[CH-1:0]        = edge_q;
                    rdata[INV_LSB +: CH] = inv_q;
                end
                ADR_SEL_LO: rdata = sel_lo_q;
                ADR_SEL_HI: rdata = sel_hi_q;
                ADR_FLT:    rdata = flt_q;
            endcase
        end
    end

    for (genvar n = 0; n < CH; n++) begin : g_cfg
        assign cfg[n].edge_en = edge_q[n];
        assign cfg[n].inv_en  = inv_q[n];
        assign cfg[n].flt     = flt_q[n*FLT_W +: FLT_W];
        if (n < PER_WORD) begin : g_lo
            assign cfg[n].sel = sel_lo_q[(n % PER_WORD)*SEL_W +: SEL_W];
        end else begin : g_hi
            assign cfg[n].sel = sel_hi_q[(n % PER_WORD)*SEL_W +: SEL_W];
        end
    end
endmodule

// File: rtl/gir_channel.sv
module gir_channel
    import gir_pkg::*;
#(
    parameter int NUM_PADS = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads_s,
    input  ch_cfg_t             cfg,
    output logic                irq
);
    logic [SPAN-1:0] ext;

    for (genvar k = 0; k < SPAN; k++) begin : g_ext
        if (k < NUM_PADS) begin : g_real
            assign ext[k] = pads_s[k];
        end else begin : g_none
            assign ext[k] = 1'b0;
        end
    end

    localparam int ROUTE_W = SEL_W + 2;

    flt_state_t       state_q, state_d;
    logic [FLT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;
    logic             prev_q, prev_d;
    logic [ROUTE_W-1:0] route_q, route_now;
    logic             v, cfg_chg;

    assign v         = ext[cfg.sel] ^ cfg.inv_en;
    assign route_now = {cfg.edge_en, cfg.inv_en, cfg.sel};
    assign cfg_chg   = (route_now != route_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_SETTLED;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
            prev_q  <= 1'b0;
            route_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
            prev_q  <= prev_d;
            route_q <= route_now;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        prev_d  = cfg_chg ? v : filt_q;
        if (cfg_chg) begin
            state_d = FLT_SETTLED;
            cnt_d   = '0;
            filt_d  = v;
        end else begin
            unique case (state_q)
                FLT_SETTLED: begin
                    if (v != filt_q) begin
                        if (cfg.flt == '0) begin
                            filt_d = v;
                        end else begin
                            state_d = FLT_QUALIFY;
                            cnt_d   = FLT_W'(1);
                        end
                    end
                end
                FLT_QUALIFY: begin
                    if (v == filt_q) begin
                        state_d = FLT_SETTLED;
                    end else if (cnt_q >= cfg.flt) begin
                        filt_d  = v;
                        state_d = FLT_SETTLED;
                    end else begin
                        cnt_d = cnt_q + FLT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        irq = cfg.edge_en ? (filt_q & ~prev_q) : filt_q;
    end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_PADS = 200,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [CH-1:0]       irq_out
);
    logic [NUM_PADS-1:0] pads_s;
    ch_cfg_t [CH-1:0]    cfg;

    gir_sync #(.W(NUM_PADS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pads),
        .q     (pads_s)
    );

    gir_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    for (genvar n = 0; n < CH; n++) begin : g_ch
        gir_channel #(.NUM_PADS(NUM_PADS)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pads_s (pads_s),
            .cfg    (cfg[n]),
            .irq    (irq_out[n])
        );
    end
endmodule

// File: rtl/gir_checker.sv
module gir_checker
    import gir_pkg::*;
#(
    parameter int NUM_PADS = 200,
    parameter int ADDR_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CH-1:0]     irq_out,
    input ch_cfg_t [CH-1:0]  cfg
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (bus_rdata == '0 && irq_out == '0));

    assert_mode_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[15:8] == '0 && bus_rdata[31:24] == '0));

    for (genvar i = 0; i < CH; i++) begin : g_chk
        assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[i].edge_en && irq_out[i]) |=> (!cfg[i].edge_en || !irq_out[i]));

        assert_out_of_range_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg[i].sel) >= NUM_PADS && !cfg[i].inv_en && !cfg[i].edge_en
             && $stable(cfg[i])) |-> !irq_out[i]);
    end
endmodule

bind gpio_irq_router gir_checker #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .cfg       (cfg)
);

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
    localparam int NP = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pads = '0;
    logic [3:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [7:0]    irq_out;

    always #5 clk = ~clk;

    gpio_irq_router #(.NUM_PADS(NP), .ADDR_W(4)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pads      (pads),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    typedef struct {
        int         at;
        logic [7:0] mask;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   now = 0;
    int   checks = 0;
    int   fails = 0;

    // monitor: compares queued expectations at each falling edge
    always @(negedge clk) begin
        exp_t e;
        now++;
        while (sb.size() > 0 && sb[0].at <= now) begin
            e = sb.pop_front();
            checks++;
            if (e.at < now || (irq_out & e.mask) !== e.val) begin
                fails++;
                $display("FAIL %s irq_out&%h actual=%h expected=%h (cycle %0d)",
                         e.tag, e.mask, irq_out & e.mask, e.val, now);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_at(int d, logic [7:0] m, logic [7:0] v, string tag);
        exp_t e;
        e.at = now + d;
        e.mask = m;
        e.val = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        tick(1);
        bus_we    = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s read addr %h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    localparam logic [31:0] MODE_C = (32'd1 << 20) | (32'd1 << 1) | (32'd1 << 2) | (32'd1 << 18);

    initial begin
        tick(3);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rd(4'h0, 32'h0, "R1");
        rd(4'h4, 32'h0, "R1");
        rd(4'h8, 32'h0, "R1");
        rd(4'hC, 32'h0, "R1");
        expect_at(1, 8'hFF, 8'h00, "R1");
        tick(2);

        // R2: readback, unused bits, misaligned access
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 32'h00FF_00FF, "R2");
        wr(4'h4, 32'hA5C3_1234);
        rd(4'h4, 32'hA5C3_1234, "R2");
        rd(4'h5, 32'h0, "R2");
        wr(4'h6, 32'h1111_1111);
        rd(4'h4, 32'hA5C3_1234, "R2");
        wr(4'h8, 32'h0BAD_F00D);
        rd(4'h8, 32'h0BAD_F00D, "R2");
        wr(4'hC, 32'h8765_4321);
        rd(4'hC, 32'h8765_4321, "R2");
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h0);
        tick(6);

        // R3 / R4: select placement and level copy
        wr(4'h4, {8'd30, 8'd20, 8'd10, 8'd3});
        wr(4'h8, {8'd199, 8'd42, 8'd41, 8'd40});
        tick(4);
        expect_at(1, 8'hFF, 8'h00, "R4");
        pads[10] = 1'b1;
        expect_at(2, 8'h02, 8'h00, "R4");
        expect_at(3, 8'hFF, 8'h02, "R3");
        tick(4);
        pads[199] = 1'b1;
        expect_at(3, 8'hFF, 8'h82, "R3");
        tick(4);
        pads[10] = 1'b0;
        pads[199] = 1'b0;
        expect_at(3, 8'h82, 8'h00, "R4");
        tick(4);

        // R5: inversion of channel 4
        wr(4'h0, 32'd1 << 20);
        tick(3);
        expect_at(1, 8'h10, 8'h10, "R5");
        pads[40] = 1'b1;
        expect_at(3, 8'h10, 8'h00, "R5");
        tick(4);
        pads[40] = 1'b0;
        expect_at(3, 8'h10, 8'h10, "R5");
        tick(4);

        // R6: rising-edge pulse on channel 1
        wr(4'h0, (32'd1 << 20) | (32'd1 << 1));
        tick(4);
        pads[10] = 1'b1;
        expect_at(2, 8'h02, 8'h00, "R6");
        expect_at(3, 8'h02, 8'h02, "R6");
        expect_at(4, 8'h02, 8'h00, "R6");
        tick(6);
        pads[10] = 1'b0;
        expect_at(3, 8'h02, 8'h00, "R6");
        expect_at(4, 8'h02, 8'h00, "R6");
        tick(6);

        // R7: falling-edge pulse on channel 2
        wr(4'h0, MODE_C);
        tick(4);
        pads[20] = 1'b1;
        expect_at(3, 8'h04, 8'h00, "R7");
        expect_at(4, 8'h04, 8'h00, "R7");
        tick(6);
        pads[20] = 1'b0;
        expect_at(2, 8'h04, 8'h00, "R7");
        expect_at(3, 8'h04, 8'h04, "R7");
        expect_at(4, 8'h04, 8'h00, "R7");
        tick(6);

        // R8: filter length 3 on channel 3
        wr(4'hC, 32'h0000_3000);
        tick(4);
        pads[30] = 1'b1;
        for (int d = 3; d <= 8; d++) expect_at(d, 8'h08, 8'h00, "R8");
        tick(3);
        pads[30] = 1'b0;
        tick(8);
        pads[30] = 1'b1;
        expect_at(5, 8'h08, 8'h00, "R8");
        expect_at(6, 8'h08, 8'h08, "R8");
        tick(8);
        pads[30] = 1'b0;
        expect_at(5, 8'h08, 8'h08, "R8");
        expect_at(6, 8'h08, 8'h00, "R8");
        tick(8);

        // R9: out-of-range select on channel 7
        pads[199] = 1'b1;
        tick(4);
        expect_at(1, 8'h80, 8'h80, "R9");
        tick(2);
        wr(4'h8, {8'd200, 8'd42, 8'd41, 8'd40});
        tick(3);
        expect_at(1, 8'h80, 8'h00, "R9");
        tick(2);
        wr(4'h8, {8'd255, 8'd42, 8'd41, 8'd40});
        pads = '1;
        tick(4);
        expect_at(1, 8'h80, 8'h00, "R9");
        tick(2);
        pads = '0;
        tick(6);

        // R10: select change onto a high pad in edge mode
        wr(4'h0, MODE_C | 32'd1);
        tick(4);
        pads[5] = 1'b1;
        tick(5);
        wr(4'h4, {8'd30, 8'd20, 8'd10, 8'd5});
        for (int d = 1; d <= 4; d++) expect_at(d, 8'h01, 8'h00, "R10");
        tick(6);
        pads[5] = 1'b0;
        tick(5);
        pads[5] = 1'b1;
        expect_at(3, 8'h01, 8'h01, "R10");
        expect_at(4, 8'h01, 8'h00, "R10");
        tick(8);

        if (sb.size() != 0) begin
            fails++;
            $display("FAIL pending expectations actual=%0d expected=0", sb.size());
        end
        summary();
    end
endmodule